// File: doc/BRIEF.md
# ADC Result Register with Completion and Overrun Flags

This block is the register front end of a 10-bit analog-to-digital converter. A converter model hands it a one-cycle done strobe with a 10-bit sample. The block latches that sample. A 16-bit register bus can then read it, padded to the right or to the left. Two status flags track the data. The ready flag says that an unread sample is waiting. The overrun flag says that a sample was replaced before anyone fetched it. Each flag has its own enable, and the two enabled flags are merged onto one level interrupt line.

The ready flag is cleared by the act of reading the sample. Software cannot write it. The overrun flag is sticky and is cleared only by writing a 1 to its bit. The padding mode is applied on the read path, so changing the mode re-presents the stored sample without a new conversion. The register map has four 16-bit slots at byte offsets 0, 2, 4 and 6. Offset 0 is the sample and offset 4 is control/status. Offsets 2 and 6 are reserved in this block and read as zero.

Control/status word at offset 4:
- bit 0: ready flag, read-only.
- bit 1: overrun flag, write 1 to clear.
- bit 2: ready interrupt enable.
- bit 3: overrun interrupt enable.
- bit 4: padding mode, 0 = right, 1 = left.
- bits 15:5: zero.

Top module: `adc_result_regs`

## Requirements
- R1: After reset the sample is 0x0000, both flags are 0, both enables are 0, the padding mode is 0 and irq is 0.
- R2: A cycle with conv_done high loads conv_data into the sample and sets the ready flag (bit 0 at offset 4), both visible from the next cycle.
- R3: A bus read of offset 0 clears the ready flag, and the flag stays 0 until the next conv_done.
- R4: A conv_done while the ready flag is 1, with no read of offset 0 in that cycle, sets the overrun flag (bit 1 at offset 4) and replaces the sample with the new data.
- R5: Writing 1 to bit 1 at offset 4 clears the overrun flag. Writing 0 there leaves it set. If a set and a clear happen in the same cycle, the set wins.
- R6: irq is high exactly when (ready flag AND bit 2) OR (overrun flag AND bit 3). It stays high until the flag or the enable is cleared.
- R7: With bit 4 at 0 the sample reads in bits 9:0 and bits 15:10 read 0. With bit 4 at 1 it reads in bits 15:6 and bits 5:0 read 0. Changing bit 4 re-formats the stored sample on the next read.
- R8: If a read of offset 0 and a conv_done happen in the same cycle, the ready flag ends up 1 and no overrun is flagged.
- R9: Writes to offset 0 and writes to bit 0 at offset 4 have no effect.
- R10: Offsets 2 and 6 read 0x0000 and ignore writes. Bits 15:5 at offset 4 read 0 whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: a new sample is on conv_data |
| conv_data | input | 10 | Sample from the converter |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high and bus_wr is low, else 0 |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take four things for granted:
- conv_done is a single-cycle strobe with stable conv_data.
- A bus access lasts exactly one cycle.
- Every bus cycle is either a read or a write, never both.
- A read that clears the ready flag is a read of offset 0 with bus_sel high.

The stimulus meets these conditions by construction. Every input changes only on the falling clock edge, from tasks that hold each strobe for exactly one cycle. A conversion and a read are made to coincide in only one deliberate case, the one R8 describes.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;

    localparam int ADDR_W = 3;

    // Register offsets (byte addresses, 16-bit slots)
    localparam logic [ADDR_W-1:0] OFS_RESULT = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CLKC   = 3'd6;

    // Control/status bit positions
    localparam int B_DONE    = 0;
    localparam int B_OVR     = 1;
    localparam int B_DONE_IE = 2;
    localparam int B_OVR_IE  = 3;
    localparam int B_ALIGN   = 4;

    typedef struct packed {
        logic done;
        logic ovr;
    } flag_t;

    typedef struct packed {
        logic done_ie;
        logic ovr_ie;
        logic align_left;
    } ctrl_t;

endpackage

// File: rtl/adc_rr_flags.sv
module adc_rr_flags
    import adc_rr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  conv_done,
    input  logic  rd_res,
    input  logic  w1c_ovr,
    output flag_t flags_q
);

    flag_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (rd_res) begin
            flags_d.done = 1'b0;
        end
        if (w1c_ovr) begin
            flags_d.ovr = 1'b0;
        end
        if (conv_done) begin
            // a completion that coincides with a read does not count as overrun
            if (flags_q.done && !rd_res) begin
                flags_d.ovr = 1'b1;
            end
            flags_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> flags_q.done);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res && !conv_done) |=> !flags_q.done);

    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.done) |-> $past(conv_done));

    a_r4_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && flags_q.done && !rd_res) |=> flags_q.ovr);

    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.ovr && !w1c_ovr) |=> flags_q.ovr);

    a_r8_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && rd_res && !flags_q.ovr) |=> (flags_q.done && !flags_q.ovr));

endmodule

// File: rtl/adc_rr_align.sv
module adc_rr_align #(
    parameter int RES_W = 10,
    parameter int BUS_W = 16
) (
    input  logic [RES_W-1:0] sample,
    input  logic             left,
    output logic [BUS_W-1:0] word
);

    localparam int PAD = BUS_W - RES_W;

    generate
        if (PAD == 0) begin : g_full
            logic unused_left;
            assign unused_left = left;
            assign word        = sample;
        end else begin : g_pad
            always_comb begin
                if (left) begin
                    word = {sample, {PAD{1'b0}}};
                end else begin
                    word = {{PAD{1'b0}}, sample};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/adc_rr_bus.sv
module adc_rr_bus
    import adc_rr_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  res_word,
    input  flag_t             flags_q,
    input  ctrl_t             ctrl_q,
    output logic              rd_res,
    output logic              w1c_ovr,
    output logic              ctrl_we,
    output ctrl_t             ctrl_wr,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic rd_cyc;
    logic wr_cyc;
    logic unused_wdata;

    assign rd_cyc = bus_sel && !bus_wr;
    assign wr_cyc = bus_sel && bus_wr;

    assign rd_res  = rd_cyc && (bus_addr == OFS_RESULT);
    assign ctrl_we = wr_cyc && (bus_addr == OFS_CTRL);
    assign w1c_ovr = ctrl_we && bus_wdata[B_OVR];

    assign ctrl_wr.done_ie    = bus_wdata[B_DONE_IE];
    assign ctrl_wr.ovr_ie     = bus_wdata[B_OVR_IE];
    assign ctrl_wr.align_left = bus_wdata[B_ALIGN];

    // read-only / reserved write bits are dropped
    assign unused_wdata = ^{bus_wdata[BUS_W-1:B_ALIGN+1], bus_wdata[B_DONE]};

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            unique case (bus_addr)
                OFS_RESULT: bus_rdata = res_word;
                OFS_CTRL: begin
                    bus_rdata[B_DONE]    = flags_q.done;
                    bus_rdata[B_OVR]     = flags_q.ovr;
                    bus_rdata[B_DONE_IE] = ctrl_q.done_ie;
                    bus_rdata[B_OVR_IE]  = ctrl_q.ovr_ie;
                    bus_rdata[B_ALIGN]   = ctrl_q.align_left;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_rr_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);

    localparam int               PAD       = BUS_W - RES_W;
    localparam logic [BUS_W-1:0] LOW_MASK  = ~({BUS_W{1'b1}} << PAD);
    localparam logic [BUS_W-1:0] HIGH_MASK = {BUS_W{1'b1}} << RES_W;

    typedef struct packed {
        logic [RES_W-1:0] sample;
        ctrl_t            ctrl;
    } regs_t;

    regs_t            regs_d;
    regs_t            regs_q;
    flag_t            flags_q;
    logic             rd_res;
    logic             w1c_ovr;
    logic             ctrl_we;
    ctrl_t            ctrl_wr;
    logic [BUS_W-1:0] res_word;

    adc_rr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .rd_res    (rd_res),
        .w1c_ovr   (w1c_ovr),
        .flags_q   (flags_q)
    );

    adc_rr_align #(
        .RES_W (RES_W),
        .BUS_W (BUS_W)
    ) u_align (
        .sample (regs_q.sample),
        .left   (regs_q.ctrl.align_left),
        .word   (res_word)
    );

    adc_rr_bus #(
        .BUS_W (BUS_W)
    ) u_bus (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .res_word  (res_word),
        .flags_q   (flags_q),
        .ctrl_q    (regs_q.ctrl),
        .rd_res    (rd_res),
        .w1c_ovr   (w1c_ovr),
        .ctrl_we   (ctrl_we),
        .ctrl_wr   (ctrl_wr),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        regs_d = regs_q;
        if (conv_done) begin
            regs_d.sample = conv_data;
        end
        if (ctrl_we) begin
            regs_d.ctrl = ctrl_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign irq = (flags_q.done && regs_q.ctrl.done_ie) ||
                 (flags_q.ovr  && regs_q.ctrl.ovr_ie);

    a_r2_sample_load: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (regs_q.sample == $past(conv_data)));

    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.ctrl.done_ie && !regs_q.ctrl.ovr_ie) |-> !irq);

    a_r6_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && regs_q.ctrl.done_ie && !ctrl_we) |=> irq);

    a_r7_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res && regs_q.ctrl.align_left) |-> ((bus_rdata & LOW_MASK) == '0));

    a_r7_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res && !regs_q.ctrl.align_left) |-> ((bus_rdata & HIGH_MASK) == '0));

    a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));

endmodule

// File: tb/adc_result_regs_tb_top.sv
`timescale 1ns/1ps
module adc_result_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_result_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl(input bit done, input bit ovr, input bit die,
                                        input bit oie, input bit left);
        return {11'b0, left, oie, die, ovr, done};
    endfunction

    task automatic conv(input logic [9:0] d);
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 0x0000 expected 0x0001");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 irq", {15'b0, irq}, 16'h0);
        rd(3'd4, r); check("R1 ctrl", r, 16'h0);
        rd(3'd0, r); check("R1 sample", r, 16'h0);

        // R10 reserved offsets and bits
        wr(3'd2, 16'hFFFF); rd(3'd2, r); check("R10 ofs2", r, 16'h0);
        wr(3'd6, 16'hFFFF); rd(3'd6, r); check("R10 ofs6", r, 16'h0);
        wr(3'd4, 16'hFFE0); rd(3'd4, r); check("R10 reserved bits", r, 16'h0);

        // R9 read-only locations
        wr(3'd0, 16'h03FF); rd(3'd0, r); check("R9 sample ro", r, 16'h0);
        wr(3'd4, 16'h0001); rd(3'd4, r); check("R9 done ro", r, 16'h0);

        // R2 R3 R7 sweep, right-padded
        for (int v = 0; v < 1024; v++) begin
            conv(v[9:0]);
            rd(3'd4, r); check("R2 done set", r, ctl(1, 0, 0, 0, 0));
            rd(3'd0, r); check("R7 right sample", r, 16'(v));
            rd(3'd4, r); check("R3 done clear", r, ctl(0, 0, 0, 0, 0));
        end

        // R7 sweep, left-padded
        wr(3'd4, 16'h0010);
        for (int v = 0; v < 1024; v++) begin
            conv(v[9:0]);
            rd(3'd0, r); check("R7 left sample", r, 16'(v << 6));
            rd(3'd4, r); check("R3 done clear left", r, ctl(0, 0, 0, 0, 1));
        end

        // R7 re-format without new conversion
        wr(3'd4, 16'h0000);
        conv(10'h2A5);
        rd(3'd0, r); check("R7 reformat right", r, 16'h02A5);
        wr(3'd4, 16'h0010);
        rd(3'd0, r); check("R7 reformat left", r, 16'hA940);
        wr(3'd4, 16'h0000);

        // R4 overrun and R5 write-1-to-clear
        conv(10'h111);
        conv(10'h222);
        rd(3'd4, r); check("R4 overrun", r, ctl(1, 1, 0, 0, 0));
        rd(3'd0, r); check("R4 replaced", r, 16'h0222);
        wr(3'd4, 16'h0000);
        rd(3'd4, r); check("R5 write0 keeps", r, ctl(0, 1, 0, 0, 0));
        wr(3'd4, 16'h0002);
        rd(3'd4, r); check("R5 write1 clears", r, ctl(0, 0, 0, 0, 0));

        // R8 read and completion in same cycle
        conv(10'h055);
        @(negedge clk);
        conv_done = 1'b1; conv_data = 10'h0AA;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0;
        #2 check("R8 old sample", bus_rdata, 16'h0055);
        @(negedge clk);
        conv_done = 1'b0; bus_sel = 1'b0;
        rd(3'd4, r); check("R8 done kept no ovr", r, ctl(1, 0, 0, 0, 0));
        rd(3'd0, r); check("R8 new sample", r, 16'h00AA);

        // R6 interrupt combining
        wr(3'd4, 16'h0004);
        #1 check("R6 idle", {15'b0, irq}, 16'h0);
        conv(10'h001);
        #1 check("R6 done irq", {15'b0, irq}, 16'h1);
        rd(3'd0, r);
        #1 check("R6 done irq cleared", {15'b0, irq}, 16'h0);
        wr(3'd4, 16'h0000);
        conv(10'h002); conv(10'h003);
        #1 check("R6 ovr masked", {15'b0, irq}, 16'h0);
        wr(3'd4, 16'h0008);
        #1 check("R6 ovr irq", {15'b0, irq}, 16'h1);
        rd(3'd0, r);
        #1 check("R6 ovr irq holds", {15'b0, irq}, 16'h1);
        wr(3'd4, 16'h000A);
        #1 check("R6 ovr irq cleared", {15'b0, irq}, 16'h0);
        rd(3'd4, r); check("R5 cleared with ie", r, ctl(0, 0, 0, 1, 0));

        finish_run();
    end

endmodule